// File: doc/BRIEF.md
# Multi-Width Shift and Rotate Unit

This block performs a single-bit shift, rotate or complement on an operand of selectable width (byte, word or long) for a small CPU datapath. It takes the operand, a size code, an operation code and the current carry flag, and returns the transformed value with a packed four-bit condition field holding negative, zero, overflow and carry flags.

All operations share one flag path. Negative follows the top bit of the selected width. Zero looks only at bits inside that width. Overflow is always cleared. Carry comes from the bit that was shifted out, or is passed through unchanged for the complement. The result is registered, so a valid strobe on the input returns a valid result one clock later, and one operation can be issued on every cycle.

Top module: `shift_rot_unit`

## Requirements
- R1: Size code 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits, and code 3 behaves as 32 bits. Operand bits above the selected width are ignored, and result bits above it are zero.
- R2: Op codes 0 and 1 (logical and arithmetic left shift) move the operand left by one and fill bit 0 with zero. C takes the old top bit of the selected width.
- R3: Op code 2 (logical right shift) moves the operand right by one and fills the top bit with zero. C takes the old bit 0.
- R4: Op code 3 (arithmetic right shift) moves the operand right by one and keeps the old top bit in place. C takes the old bit 0.
- R5: Op code 4 (rotate left) places the old top bit in both bit 0 and C. Op code 5 (rotate right) places the old bit 0 in both the top bit and C.
- R6: Op code 6 (rotate left through carry) moves the incoming carry into bit 0 and the old top bit into C. Op code 7 (rotate right through carry) moves the incoming carry into the top bit and the old bit 0 into C.
- R7: Op code 8 inverts every bit of the selected width and leaves C equal to the incoming carry.
- R8: Op codes 9 to 15 pass the width-masked operand through unchanged and leave C equal to the incoming carry.
- R9: The condition output carries N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. N equals the top bit of the result within the selected width. Z is set when the result within that width is all zero. V is always 0.
- R10: A cycle with in_valid high produces out_valid high, with its result and flags, on the next cycle.
- R11: Synchronous active-high reset clears out_valid, out_data and out_ccr.
- R12: A cycle with in_valid low makes out_valid low on the next cycle, and out_data and out_ccr keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| in_size | input | 2 | Width select: 0 byte, 1 word, 2 or 3 long |
| in_op | input | 4 | Operation code |
| in_carry | input | 1 | Current carry flag |
| in_data | input | 32 | Operand |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_data | output | 32 | Result, zero above the selected width |
| out_ccr | output | 4 | Flags: N bit 3, Z bit 2, V bit 1, C bit 0 |

## Verification
The bench builds the unit with its default 32-bit data path, so the byte, word and long widths sit at 8, 16 and 32 bits. It sweeps all four size codes, all sixteen op codes and both carry values over a set of operands. The operands include all-zero, all-one, lone top-bit and lone bottom-bit patterns at each width, along with pseudo-random words. This brings every shift-out boundary, every zero-flag edge and the undefined op and size codes within reach. Idle cycles between operations exercise the hold behaviour of the output register.

// File: rtl/sru_pkg.sv
package sru_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  localparam logic [3:0] OPC_SHLL  = 4'd0;
  localparam logic [3:0] OPC_SHAL  = 4'd1;
  localparam logic [3:0] OPC_SHLR  = 4'd2;
  localparam logic [3:0] OPC_SHAR  = 4'd3;
  localparam logic [3:0] OPC_ROTL  = 4'd4;
  localparam logic [3:0] OPC_ROTR  = 4'd5;
  localparam logic [3:0] OPC_ROTXL = 4'd6;
  localparam logic [3:0] OPC_ROTXR = 4'd7;
  localparam logic [3:0] OPC_NOT   = 4'd8;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

endpackage

// File: rtl/sru_width_sel.sv
module sru_width_sel #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size_code,
  output logic [DATA_W-1:0] width_mask,
  output logic [DATA_W-1:0] top_bit
);
  import sru_pkg::*;

  localparam int BYTE_W = DATA_W / 4;
  localparam int WORD_W = DATA_W / 2;

  localparam logic [DATA_W-1:0] MASK_B = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_W = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_L = {DATA_W{1'b1}};

  always_comb begin
    case (size_code)
      SZ_BYTE: width_mask = MASK_B;
      SZ_WORD: width_mask = MASK_W;
      default: width_mask = MASK_L;
    endcase
  end

  // the highest set bit of a contiguous low mask
  assign top_bit = width_mask ^ (width_mask >> 1);

endmodule

// File: rtl/sru_core.sv
module sru_core #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] width_mask,
  input  logic [DATA_W-1:0] top_bit,
  input  logic [3:0]        opcode,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              old_top,
  output logic              old_bottom
);
  import sru_pkg::*;

  logic [DATA_W-1:0] masked;

  function automatic logic [DATA_W-1:0] step_left(
    input logic [DATA_W-1:0] x, input logic fill, input logic [DATA_W-1:0] m);
    return ((x << 1) | {{(DATA_W-1){1'b0}}, fill}) & m;
  endfunction

  function automatic logic [DATA_W-1:0] step_right(
    input logic [DATA_W-1:0] x, input logic fill, input logic [DATA_W-1:0] tb);
    return (x >> 1) | (fill ? tb : '0);
  endfunction

  assign masked     = operand & width_mask;
  assign old_top    = |(masked & top_bit);
  assign old_bottom = masked[0];

  always_comb begin
    result    = masked;
    carry_out = carry_in;
    case (opcode)
      OPC_SHLL, OPC_SHAL: begin
        result    = step_left(masked, 1'b0, width_mask);
        carry_out = old_top;
      end
      OPC_SHLR: begin
        result    = step_right(masked, 1'b0, top_bit);
        carry_out = old_bottom;
      end
      OPC_SHAR: begin
        result    = step_right(masked, old_top, top_bit);
        carry_out = old_bottom;
      end
      OPC_ROTL: begin
        result    = step_left(masked, old_top, width_mask);
        carry_out = old_top;
      end
      OPC_ROTR: begin
        result    = step_right(masked, old_bottom, top_bit);
        carry_out = old_bottom;
      end
      OPC_ROTXL: begin
        result    = step_left(masked, carry_in, width_mask);
        carry_out = old_top;
      end
      OPC_ROTXR: begin
        result    = step_right(masked, carry_in, top_bit);
        carry_out = old_bottom;
      end
      OPC_NOT: begin
        result    = ~masked & width_mask;
        carry_out = carry_in;
      end
      default: begin
        result    = masked;
        carry_out = carry_in;
      end
    endcase
  end

endmodule

// File: rtl/sru_flags.sv
module sru_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] top_bit,
  input  logic              carry,
  output sru_pkg::ccr_t     flags
);
  always_comb begin
    flags.n = |(result & top_bit);
    flags.z = (result == '0);
    flags.v = 1'b0;
    flags.c = carry;
  end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_size,
  input  logic [3:0]        in_op,
  input  logic              in_carry,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [3:0]        out_ccr
);
  import sru_pkg::*;

  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] top_bit;
  logic [DATA_W-1:0] core_result;
  logic              core_carry;
  logic              old_top;
  logic              old_bottom;
  ccr_t              next_flags;

  sru_width_sel #(.DATA_W(DATA_W)) u_width (
    .size_code  (in_size),
    .width_mask (width_mask),
    .top_bit    (top_bit)
  );

  sru_core #(.DATA_W(DATA_W)) u_core (
    .operand    (in_data),
    .width_mask (width_mask),
    .top_bit    (top_bit),
    .opcode     (in_op),
    .carry_in   (in_carry),
    .result     (core_result),
    .carry_out  (core_carry),
    .old_top    (old_top),
    .old_bottom (old_bottom)
  );

  sru_flags #(.DATA_W(DATA_W)) u_flags (
    .result (core_result),
    .top_bit(top_bit),
    .carry  (core_carry),
    .flags  (next_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ccr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= core_result;
        out_ccr  <= next_flags;
      end
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((core_result & ~width_mask) == '0)); // R1
  AST_TOP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ($countones(top_bit) == 1)); // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_ccr))); // R12
  AST_V_CLEAR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_ccr[1]); // R9
  AST_Z_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ccr[2] == (out_data == '0))); // R9
  AST_NOT_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OPC_NOT) |=> (out_ccr[0] == $past(in_carry))); // R7
  AST_LEFT_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == OPC_SHLL || in_op == OPC_SHAL)) |=> (out_ccr[0] == $past(old_top))); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && out_ccr == '0)); // R11

endmodule

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_size = 2'd0;
  logic [3:0]  in_op = 4'd0;
  logic        in_carry = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [3:0]  out_ccr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shift_rot_unit u_shift_rot_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
    .in_op(in_op), .in_carry(in_carry), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_ccr(out_ccr)
  );

  function automatic int width_of(input logic [1:0] s);
    if (s == 2'd0) return 8;
    if (s == 2'd1) return 16;
    return 32;
  endfunction

  // bitwise reference: returns {flags, result}
  function automatic logic [35:0] model(input logic [1:0] s, input logic [3:0] op,
                                        input logic c, input logic [31:0] d);
    int w = width_of(s);
    logic [31:0] r = 32'd0;
    logic co = c;
    logic msb = d[w-1];
    logic lsb = d[0];
    logic fill;
    logic zero;
    for (int i = 0; i < w; i++) begin
      case (op)
        4'd0, 4'd1: r[i] = (i == 0) ? 1'b0 : d[i-1];
        4'd4:       r[i] = (i == 0) ? msb  : d[i-1];
        4'd6:       r[i] = (i == 0) ? c    : d[i-1];
        4'd2, 4'd3, 4'd5, 4'd7: begin
          fill = (op == 4'd2) ? 1'b0 : (op == 4'd3) ? msb : (op == 4'd5) ? lsb : c;
          r[i] = (i == w-1) ? fill : d[i+1];
        end
        4'd8:       r[i] = !d[i];
        default:    r[i] = d[i];
      endcase
    end
    if (op == 4'd0 || op == 4'd1 || op == 4'd4 || op == 4'd6) co = msb;
    else if (op == 4'd2 || op == 4'd3 || op == 4'd5 || op == 4'd7) co = lsb;
    zero = 1'b1;
    for (int i = 0; i < w; i++) if (r[i]) zero = 1'b0;
    return {r[w-1], zero, 1'b0, co, r};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] pattern(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h0000_8000;
      4: return 32'h0000_0080;
      5: return 32'h0000_0001;
      6: return 32'h5555_5555;
      7: return 32'hAAAA_AAAA;
      8: return 32'h0000_007F;
      9: return 32'hFFFF_FF00;
      10: return 32'h0001_0000;
      default: return 32'h9E37_79B9 * (k * 2 + 1) ^ (32'h1234_5678 << (k % 7));
    endcase
  endfunction

  task automatic fail_line(input string tag, input logic [35:0] act, input logic [35:0] exp);
    failures++;
    $display("FAIL %s actual ccr=%h data=%h expected ccr=%h data=%h",
             tag, act[35:32], act[31:0], exp[35:32], exp[31:0]);
  endtask

  task automatic run_op(input logic [1:0] s, input logic [3:0] op, input logic c,
                        input logic [31:0] d);
    logic [35:0] exp;
    int w;
    @(negedge clk);
    in_valid = 1'b1; in_size = s; in_op = op; in_carry = c; in_data = d;
    exp = model(s, op, c, d);
    w = width_of(s);
    @(posedge clk); #1;
    checks++;
    if (!out_valid) begin
      failures++;
      $display("FAIL R10 actual valid=%b expected valid=1", out_valid);
    end
    checks++;
    if (out_data != exp[31:0]) begin
      if (w < 32 && (out_data >> w) != 0) fail_line("R1", {out_ccr, out_data}, exp);
      else fail_line(tag_of(op), {out_ccr, out_data}, exp);
    end
    checks++;
    if (out_ccr[0] != exp[32]) fail_line(tag_of(op), {out_ccr, out_data}, exp);
    checks++;
    if (out_ccr[3:1] != exp[35:33]) fail_line("R9", {out_ccr, out_data}, exp);
  endtask

  task automatic idle_check;
    logic [31:0] hd;
    logic [3:0] hc;
    hd = out_data; hc = out_ccr;
    @(negedge clk);
    in_valid = 1'b0; in_data = ~in_data; in_op = 4'd8;
    @(posedge clk); #1;
    checks++;
    if (out_valid || out_data != hd || out_ccr != hc) begin
      failures++;
      $display("FAIL R12 actual valid=%b data=%h ccr=%h expected valid=0 data=%h ccr=%h",
               out_valid, out_data, out_ccr, hd, hc);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    // R11: reset state with a request pending
    in_valid = 1'b1; in_data = 32'hFFFF_FFFF; in_op = 4'd8;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid || out_data != 0 || out_ccr != 0) begin
      failures++;
      $display("FAIL R11 actual valid=%b data=%h ccr=%h expected 0 0 0",
               out_valid, out_data, out_ccr);
    end
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    // R1..R9 sweep: every size code, op code, carry and operand
    for (int s = 0; s < 4; s++)
      for (int op = 0; op < 16; op++)
        for (int c = 0; c < 2; c++)
          for (int k = 0; k < 16; k++)
            run_op(2'(s), 4'(op), 1'(c), pattern(k));
    // R12: hold on idle after a known result, back-to-back then idle
    run_op(2'd1, 4'd6, 1'b1, 32'h0000_8001);
    idle_check();
    idle_check();
    run_op(2'd0, 4'd3, 1'b0, 32'h1234_5681);
    idle_check();
    // R11: reset mid-stream clears outputs
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (out_valid || out_data != 0 || out_ccr != 0) begin
      failures++;
      $display("FAIL R11 actual valid=%b data=%h ccr=%h expected 0 0 0",
               out_valid, out_data, out_ccr);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule